// File: doc/BRIEF.md
# Key-Scan Interrupt Source Selector

This block drives one external interrupt request line from one of two sources: a dedicated interrupt pin, or a group of active-low key inputs. A two-bit mode field in a control register picks the source. The key inputs are inverted and ORed, so a key pulled low counts as a press. The line given to the edge stage is the complement of that "any key pressed" signal. It sits high while all keys are released and falls when a key is pressed. Key presses therefore follow the same falling-edge rule as the pin.

Every raw input first passes through a two-flop synchronizer. The selected level then goes to an edge detector, which sets a sticky request flag. Software clears the flag by writing the clear bit. The block also exports one pull-up enable per key. An enable is high only when pull-ups are selected for that key's group and the key's direction bit marks it as an input.

Top module: `keyirq_top`

## Requirements
- R1: After reset, irq_req_o is 0, the mode is pin source (00), the edge polarity is falling, and every pullup_en_o bit is 0.
- R2: In mode 00 (ctrl bits [7:6]) with falling polarity (ctrl bit 4 = 0), a high-to-low change on irq_pin_i sets irq_req_o. The flag is high after the third rising clock edge that follows the input change, and still low after the second.
- R3: Mode 01 behaves exactly like mode 00: the pin is the source, and key inputs have no effect on irq_req_o.
- R4: In mode 10, driving any one of keys 0 to 3 low sets the request, while key 4 and the pin have no effect.
- R5: In mode 11, driving any one of keys 0 to 4 low sets the request, and the pin has no effect.
- R6: With ctrl bit 4 = 1, a low-to-high change on the selected line sets the request, and a high-to-low change does not.
- R7: The request stays high until a control write with bit 3 = 1. That write clears it at the clock edge that captures the write.
- R8: If a set event and a clear write occur on the same clock edge, the request is left set.
- R9: Changing the mode field never creates a request by itself, even when the old and new sources sit at different levels.
- R10: Bits [1:0] of the control register select pull-ups: bit 0 covers keys 0 to 3, and bit 1 covers key 4. pullup_en_o[i] is 1 exactly when the key's group bit is 1 and key_dir_i[i] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 1 | Dedicated external interrupt pin, raw |
| key_n_i | input | KEYS (5) | Active-low key inputs, raw |
| key_dir_i | input | KEYS (5) | Port direction per key, 0 means input |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Write data: [7:6] mode, [4] rising polarity, [3] clear request, [1:0] pull-up selects |
| pullup_en_o | output | KEYS (5) | Pull-up enable per key |
| irq_req_o | output | 1 | Sticky interrupt request flag |

## Verification
An input change applied between clock edges reaches irq_req_o after three rising edges. Two of those edges are the synchronizer and one is the flag register. The bench therefore checks for "not yet" after two edges and "set" after three, and waits four edges before judging whether an input had any effect. Control writes act on the edge that captures them, and the pull-up enables follow key_dir_i combinationally. The pull-up checks sample one time step after the direction change, and the clear and set-wins checks sample on the falling edge right after the capturing rising edge. The sweep runs every mode against the pin and each of the five keys, and every pull-up select against all 32 direction patterns.

// File: rtl/keyirq_pkg.sv
package keyirq_pkg;

   typedef enum logic [1:0] {
      SRC_PIN      = 2'b00,
      SRC_PIN_ALT  = 2'b01,
      SRC_KEYS_LO  = 2'b10,
      SRC_KEYS_ALL = 2'b11
   } src_mode_e;

   localparam int CTRL_W   = 8;
   localparam int MODE_HI  = 7;
   localparam int MODE_LO  = 6;
   localparam int RISE_BIT = 4;
   localparam int CLR_BIT  = 3;
   localparam int PU_HI    = 1;
   localparam int PU_LO    = 0;
   localparam int PU_GRPS  = PU_HI - PU_LO + 1;

endpackage

// File: rtl/keyirq_sync.sv
module keyirq_sync #(
   parameter int          WIDTH   = 6,
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("keyirq_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stage_q[s] <= {WIDTH{RST_VAL}};
            end else if (s == 0) begin
               stage_q[s] <= d_i;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/keyirq_srcsel.sv
module keyirq_srcsel
   import keyirq_pkg::*;
#(
   parameter int KEYS    = 5,
   parameter int KEYS_LO = 4
) (
   input  src_mode_e       mode_i,
   input  logic            pin_i,
   input  logic [KEYS-1:0] key_n_i,
   output logic            line_o
);

   logic [KEYS-1:0] lo_mask;
   logic            pressed_lo;
   logic            pressed_all;

   generate
      for (genvar k = 0; k < KEYS; k++) begin : g_mask
         assign lo_mask[k] = (k < KEYS_LO);
      end
   endgenerate

   assign pressed_lo  = |(~key_n_i & lo_mask);
   assign pressed_all = |(~key_n_i);

   always_comb begin
      unique case (mode_i)
         SRC_KEYS_LO:  line_o = ~pressed_lo;
         SRC_KEYS_ALL: line_o = ~pressed_all;
         default:      line_o = pin_i;
      endcase
   end

endmodule

// File: rtl/keyirq_edge.sv
module keyirq_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic rise_i,
   input  logic hold_i,
   input  logic clr_i,
   output logic irq_o
);

   logic prev_q;
   logic irq_q;
   logic edge_seen;
   logic set_evt;

   assign edge_seen = rise_i ? (line_i & ~prev_q) : (~line_i & prev_q);
   assign set_evt   = edge_seen & ~hold_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b1;
         irq_q  <= 1'b0;
      end else begin
         prev_q <= line_i;
         if (set_evt) begin
            irq_q <= 1'b1;
         end else if (clr_i) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign irq_o = irq_q;

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_evt && clr_i) |=> irq_q); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_q && !clr_i) |=> irq_q); // R7
   AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_evt) |=> !irq_q); // R7
   AST_NO_MODE_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_i && !irq_q) |=> !irq_q); // R9

endmodule

// File: rtl/keyirq_top.sv
module keyirq_top
   import keyirq_pkg::*;
#(
   parameter int KEYS        = 5,
   parameter int KEYS_LO     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              irq_pin_i,
   input  logic [KEYS-1:0]   key_n_i,
   input  logic [KEYS-1:0]   key_dir_i,
   input  logic              ctrl_we_i,
   input  logic [CTRL_W-1:0] ctrl_wdata_i,
   output logic [KEYS-1:0]   pullup_en_o,
   output logic              irq_req_o
);

   localparam int RAW_W = KEYS + 1;

   generate
      if (KEYS_LO < 1 || KEYS_LO >= KEYS) begin : g_bad_keys
         $error("keyirq_top: KEYS_LO must lie in 1..KEYS-1");
      end
   endgenerate

   src_mode_e          mode_q;
   src_mode_e          mode_d1_q;
   logic               rise_q;
   logic [PU_GRPS-1:0] pu_sel_q;
   logic               clr_req;
   logic               mode_hold;
   logic [RAW_W-1:0]   raw_in;
   logic [RAW_W-1:0]   sync_q;
   logic               src_line;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q    <= SRC_PIN;
         mode_d1_q <= SRC_PIN;
         rise_q    <= 1'b0;
         pu_sel_q  <= '0;
      end else begin
         mode_d1_q <= mode_q;
         if (ctrl_we_i) begin
            mode_q   <= src_mode_e'(ctrl_wdata_i[MODE_HI:MODE_LO]);
            rise_q   <= ctrl_wdata_i[RISE_BIT];
            pu_sel_q <= ctrl_wdata_i[PU_HI:PU_LO];
         end
      end
   end

   assign clr_req   = ctrl_we_i & ctrl_wdata_i[CLR_BIT];
   assign mode_hold = (mode_q != mode_d1_q);
   assign raw_in    = {key_n_i, irq_pin_i};

   keyirq_sync #(
      .WIDTH   (RAW_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in),
      .q_o    (sync_q)
   );

   keyirq_srcsel #(
      .KEYS    (KEYS),
      .KEYS_LO (KEYS_LO)
   ) srcsel_i (
      .mode_i  (mode_q),
      .pin_i   (sync_q[0]),
      .key_n_i (sync_q[RAW_W-1:1]),
      .line_o  (src_line)
   );

   keyirq_edge edge_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (src_line),
      .rise_i (rise_q),
      .hold_i (mode_hold),
      .clr_i  (clr_req),
      .irq_o  (irq_req_o)
   );

   generate
      for (genvar k = 0; k < KEYS; k++) begin : g_pullup
         localparam int GRP = (k < KEYS_LO) ? 0 : 1;
         assign pullup_en_o[k] = pu_sel_q[GRP] & ~key_dir_i[k];
      end
   endgenerate

   AST_PIN_MODES_USE_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_q[1]) |-> (src_line == sync_q[0])); // R3
   AST_PULLUP_INPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pullup_en_o & key_dir_i) == '0)); // R10

endmodule

// File: tb/keyirq_top_tb_top.sv
module keyirq_top_tb_top;

   localparam int KEYS = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pin = 1'b1;
   logic [KEYS-1:0] key_n = '1;
   logic [KEYS-1:0] dir = '0;
   logic            we = 1'b0;
   logic [7:0]      wdata = '0;
   logic [KEYS-1:0] pu_en;
   logic            irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [1:0] cur_mode = 2'b00;
   logic       cur_rise = 1'b0;
   logic [1:0] cur_pu   = 2'b00;

   always #2 clk = ~clk;

   keyirq_top dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .irq_pin_i    (pin),
      .key_n_i      (key_n),
      .key_dir_i    (dir),
      .ctrl_we_i    (we),
      .ctrl_wdata_i (wdata),
      .pullup_en_o  (pu_en),
      .irq_req_o    (irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [1:0] mode, logic rise, logic clr, logic [1:0] pu);
      we    = 1'b1;
      wdata = {mode, 1'b0, rise, clr, 1'b0, pu};
      cur_mode = mode;
      cur_rise = rise;
      cur_pu   = pu;
      @(posedge clk);
      @(negedge clk);
      we    = 1'b0;
      wdata = '0;
   endtask

   task automatic clear_req();
      wr(cur_mode, cur_rise, 1'b1, cur_pu);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      check("R1 irq", irq, 0);
      check("R1 pullups", pu_en, 0);
      pin = 1'b0;
      cyc(4);
      check("R1 default mode is pin", irq, 1);
      pin = 1'b1;
      cyc(4);
      clear_req();
      check("R7 clear", irq, 0);

      // R2 latency through the synchronizer and flag register
      pin = 1'b0;
      cyc(2);
      check("R2 not before third edge", irq, 0);
      cyc(1);
      check("R2 set on third edge", irq, 1);
      cyc(6);
      check("R7 sticky", irq, 1);
      pin = 1'b1;
      cyc(4);
      clear_req();
      check("R7 cleared by write", irq, 0);

      // Sweep: every mode against pin and each key (R2 R3 R4 R5)
      for (int m = 0; m < 4; m++) begin
         wr(m[1:0], 1'b0, 1'b1, 2'b00);
         cyc(3);
         pin = 1'b0;
         cyc(4);
         check((m < 2) ? "R3 pin source" : "R4/R5 pin ignored in key mode",
               irq, (m < 2) ? 1 : 0);
         pin = 1'b1;
         cyc(4);
         clear_req();
         cyc(1);
         for (int k = 0; k < KEYS; k++) begin
            key_n[k] = 1'b0;
            cyc(4);
            if (m < 2)
               check("R3 key ignored in pin mode", irq, 0);
            else if (m == 2)
               check("R4 narrow key group", irq, (k < 4) ? 1 : 0);
            else
               check("R5 wide key group", irq, 1);
            key_n[k] = 1'b1;
            cyc(4);
            clear_req();
            cyc(1);
         end
      end

      // R6 rising polarity on the pin
      wr(2'b00, 1'b1, 1'b1, 2'b00);
      cyc(3);
      pin = 1'b0;
      cyc(4);
      check("R6 falling ignored when rising selected", irq, 0);
      pin = 1'b1;
      cyc(4);
      check("R6 rising sets", irq, 1);
      clear_req();
      cyc(1);

      // R9 mode change with differing source levels (falling polarity)
      wr(2'b00, 1'b0, 1'b1, 2'b00);
      key_n[0] = 1'b0;
      cyc(4);
      check("R9 precondition pin high", irq, 0);
      wr(2'b10, 1'b0, 1'b0, 2'b00);
      cyc(5);
      check("R9 no request on 00->10", irq, 0);
      key_n[0] = 1'b1;
      cyc(4);
      // R9 with rising polarity: pin low, keys idle, switch to 11
      pin = 1'b0;
      wr(2'b00, 1'b1, 1'b1, 2'b00);
      cyc(4);
      wr(2'b11, 1'b1, 1'b0, 2'b00);
      cyc(5);
      check("R9 no request on 00->11", irq, 0);
      key_n[2] = 1'b0;
      cyc(4);
      check("R6 key press is a falling line", irq, 0);
      key_n[2] = 1'b1;
      cyc(4);
      check("R6 key release rises line", irq, 1);
      pin = 1'b1;

      // R8 set and clear on the same edge
      wr(2'b00, 1'b0, 1'b0, 2'b00);
      cyc(4);
      check("R8 flag set beforehand", irq, 1);
      pin = 1'b0;
      cyc(2);
      we = 1'b1;
      wdata = {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00};
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
      wdata = '0;
      check("R8 set wins over clear", irq, 1);
      clear_req();
      check("R8 clear afterwards", irq, 0);
      pin = 1'b1;
      cyc(4);

      // R10 pull-up enables over every select and direction pattern
      for (int p = 0; p < 4; p++) begin
         wr(cur_mode, cur_rise, 1'b0, p[1:0]);
         for (int d = 0; d < 32; d++) begin
            logic [KEYS-1:0] exp_pu;
            dir = d[KEYS-1:0];
            #1;
            for (int k = 0; k < KEYS; k++)
               exp_pu[k] = ((k < 4) ? p[0] : p[1]) & ~d[k];
            check("R10 pull-up enable", pu_en, exp_pu);
         end
      end
      check("R10 no request from pull-up writes", irq, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule